// File: doc/BRIEF.md
# Streaming ROM Image Header Validator

This block checks the structure of a cartridge image that arrives one byte at a time. The host drives the total file length and pulses `start`. The validator then takes bytes from a valid/ready stream and walks the header, which holds a signature byte, a segment count and the complement of that count. Next come the segments. Each one opens with a low and a high page byte, followed by a page-sized payload and a two-byte checksum word. After the last segment comes a fixed-size enable-table region. The validator checks that the header fields agree with one another and that every segment range is ordered. It also checks, after each segment, that enough of the file remains for the table region. Payload and checksum bytes are counted past, not interpreted. When the walk ends, `done` is raised. `error` tells whether the image was rejected, and `body_len` gives the image length without any trailing tag bytes.

Stream rules: a byte moves on every rising edge where `s_valid` and `s_ready` are both high. The source must hold `s_data` steady, and keep `s_valid` high, for as long as the validator holds `s_ready` low against a byte it has offered. `s_ready` is high only while a walk is in progress. It drops in the cycle after the deciding byte, so no byte beyond that one is taken. A new `start` pulse begins a fresh walk from any state.

Defaults: pages are `PAGE_BYTES` = 512 bytes, the table region is `TABLE_BYTES` = 50 bytes, and the smallest accepted body is `MIN_BODY` + 1 = 53 bytes.

Top module: `rom_img_validator`

## Requirements
- R1: After reset, `done`, `error`, `s_ready` and `body_len` are all 0. A `start` pulse latches `file_len`, clears `done`, `error` and `body_len`, and raises `s_ready` from the next cycle.
- R2: Byte 0 must be 0xA8, 0x61 or 0x41. Any other value ends the walk with an error.
- R3: Byte 1 is the segment count. A value outside 1 to 32 inclusive ends the walk with an error.
- R4: Byte 2 must equal byte 1 XOR 0xFF, or the walk ends with an error.
- R5: Each segment starts with a low page byte, then a high page byte. If low is greater than high, the walk ends with an error once the high byte is taken.
- R6: After its two page bytes, a segment spans exactly (high + 1 − low) × `PAGE_BYTES` + 2 further bytes. These are taken without inspection, and the next segment's low byte follows at once.
- R7: After the last byte of each segment, let P be the count of bytes taken so far. If P > `file_len` − `TABLE_BYTES`, the walk ends with an error.
- R8: After the last segment, exactly `TABLE_BYTES` more bytes are taken. `body_len` then becomes min(P, `file_len`), where P is the total count of bytes taken.
- R9: If that body length is at most `MIN_BODY`, the walk ends with an error.
- R10: On an error, `body_len` is 0. Once `done` is high, `s_ready` stays low. `done`, `error` and `body_len` hold their values until the next `start`.
- R11: `done` rises on the same clock edge that takes the byte that decides the result, so the count of bytes taken equals the position of that byte plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a new walk and latches `file_len` |
| file_len | input | LEN_W | Total length of the image file in bytes |
| s_valid | input | 1 | Stream byte offered |
| s_ready | output | 1 | Validator takes the offered byte |
| s_data | input | 8 | Stream byte |
| done | output | 1 | Walk finished |
| error | output | 1 | Image rejected (valid while `done`) |
| body_len | output | LEN_W | Body length excluding trailing tags, 0 on error |

## Verification
Every result is registered on the edge that takes the deciding byte. The bench drives its inputs at the falling edge. It counts a transfer only when `s_valid` and `s_ready` are both seen high at that falling edge. It reads `done`, `error` and `body_len` at the first falling edge after the final transfer. The number of transfers is compared with the expected position of the deciding byte plus one. That comparison pins down the exact cycle in which `done` appears. After `done`, the bench keeps offering bytes for four more cycles and counts any that get accepted. `s_ready` is checked at the falling edge after `start`.

// File: rtl/rv_pkg.sv
package rv_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SIGN,
    ST_COUNT,
    ST_CMPL,
    ST_PG_LO,
    ST_PG_HI,
    ST_SKIP,
    ST_TABLE,
    ST_DONE
  } rv_state_e;

  localparam int NUM_SIGNS = 3;
  localparam logic [7:0] SIGN_CODES [NUM_SIGNS] = '{8'hA8, 8'h61, 8'h41};
  localparam int MAX_SEGS  = 32;
  localparam int CRC_BYTES = 2;

endpackage

// File: rtl/rv_header_check.sv
module rv_header_check
  import rv_pkg::*;
(
  input  logic [7:0] byte_in,
  input  logic [7:0] count_q,
  output logic       sign_ok,
  output logic       count_ok,
  output logic       cmpl_ok
);

  logic [NUM_SIGNS-1:0] sign_hit;

  for (genvar g = 0; g < NUM_SIGNS; g++) begin : g_sign
    assign sign_hit[g] = (byte_in == SIGN_CODES[g]);
  end

  assign sign_ok  = |sign_hit;
  assign count_ok = (byte_in != 8'd0) && (byte_in <= 8'(MAX_SEGS));
  assign cmpl_ok  = (byte_in == ~count_q);

endmodule

// File: rtl/rv_segment_calc.sv
module rv_segment_calc
  import rv_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int SKIP_W     = 18
) (
  input  logic [7:0]        lo_q,
  input  logic [7:0]        hi_in,
  output logic              range_ok,
  output logic [SKIP_W-1:0] skip_last
);

  localparam logic [SKIP_W-1:0] PAGE_C = SKIP_W'(PAGE_BYTES);
  localparam logic [SKIP_W-1:0] TAIL_C = SKIP_W'(CRC_BYTES - 1);

  logic [8:0] pages;

  assign range_ok  = (lo_q <= hi_in);
  assign pages     = {1'b0, hi_in} + 9'd1 - {1'b0, lo_q};
  // index of the last byte of payload plus checksum, counting from zero
  assign skip_last = SKIP_W'(pages) * PAGE_C + TAIL_C;

endmodule

// File: rtl/rv_limit_check.sv
module rv_limit_check #(
  parameter int LEN_W       = 24,
  parameter int TABLE_BYTES = 50,
  parameter int MIN_BODY    = 52
) (
  input  logic [LEN_W:0]   pos_next,
  input  logic [LEN_W-1:0] flen_q,
  output logic             trunc,
  output logic [LEN_W-1:0] body,
  output logic             body_small
);

  localparam logic [LEN_W+1:0] TBL_C = (LEN_W+2)'(TABLE_BYTES);

  logic [LEN_W+1:0] reach;
  logic [LEN_W:0]   flen_x;

  assign flen_x     = {1'b0, flen_q};
  assign reach      = {1'b0, pos_next} + TBL_C;
  assign trunc      = reach > {1'b0, flen_x};
  assign body       = (pos_next < flen_x) ? pos_next[LEN_W-1:0] : flen_q;
  assign body_small = body <= LEN_W'(MIN_BODY);

endmodule

// File: rtl/rom_img_validator.sv
module rom_img_validator
  import rv_pkg::*;
#(
  parameter int LEN_W       = 24,
  parameter int PAGE_BYTES  = 512,
  parameter int TABLE_BYTES = 50,
  parameter int MIN_BODY    = 52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] file_len,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  output logic             done,
  output logic             error,
  output logic [LEN_W-1:0] body_len
);

  localparam int POS_W  = LEN_W + 1;
  localparam int SKIP_W = $clog2(256 * PAGE_BYTES + CRC_BYTES + TABLE_BYTES + 1);
  localparam int SEG_W  = $clog2(MAX_SEGS + 1);

  rv_state_e         state;
  logic [POS_W-1:0]  pos;
  logic [LEN_W-1:0]  flen_q;
  logic [7:0]        count_q;
  logic [7:0]        lo_q;
  logic [SEG_W-1:0]  seg_left;
  logic [SKIP_W-1:0] skip_cnt;
  logic              err_q;
  logic [LEN_W-1:0]  body_q;

  logic              fire;
  logic [POS_W-1:0]  pos_next;
  logic              sign_ok, count_ok, cmpl_ok;
  logic              range_ok;
  logic [SKIP_W-1:0] skip_last;
  logic              trunc, body_small;
  logic [LEN_W-1:0]  body_calc;

  rv_header_check u_hdr (
    .byte_in  (s_data),
    .count_q  (count_q),
    .sign_ok  (sign_ok),
    .count_ok (count_ok),
    .cmpl_ok  (cmpl_ok)
  );

  rv_segment_calc #(
    .PAGE_BYTES (PAGE_BYTES),
    .SKIP_W     (SKIP_W)
  ) u_seg (
    .lo_q      (lo_q),
    .hi_in     (s_data),
    .range_ok  (range_ok),
    .skip_last (skip_last)
  );

  rv_limit_check #(
    .LEN_W       (LEN_W),
    .TABLE_BYTES (TABLE_BYTES),
    .MIN_BODY    (MIN_BODY)
  ) u_lim (
    .pos_next   (pos_next),
    .flen_q     (flen_q),
    .trunc      (trunc),
    .body       (body_calc),
    .body_small (body_small)
  );

  assign s_ready  = (state != ST_IDLE) && (state != ST_DONE);
  assign fire     = s_valid && s_ready;
  assign pos_next = pos + POS_W'(1);

  assign done     = (state == ST_DONE);
  assign error    = err_q;
  assign body_len = body_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pos      <= '0;
      flen_q   <= '0;
      count_q  <= '0;
      lo_q     <= '0;
      seg_left <= '0;
      skip_cnt <= '0;
      err_q    <= 1'b0;
      body_q   <= '0;
    end else if (start) begin
      state  <= ST_SIGN;
      pos    <= '0;
      flen_q <= file_len;
      err_q  <= 1'b0;
      body_q <= '0;
    end else if (fire) begin
      pos <= pos_next;
      unique case (state)
        ST_SIGN: begin
          if (sign_ok) state <= ST_COUNT;
          else begin state <= ST_DONE; err_q <= 1'b1; end
        end
        ST_COUNT: begin
          count_q <= s_data;
          if (count_ok) state <= ST_CMPL;
          else begin state <= ST_DONE; err_q <= 1'b1; end
        end
        ST_CMPL: begin
          seg_left <= count_q[SEG_W-1:0];
          if (cmpl_ok) state <= ST_PG_LO;
          else begin state <= ST_DONE; err_q <= 1'b1; end
        end
        ST_PG_LO: begin
          lo_q  <= s_data;
          state <= ST_PG_HI;
        end
        ST_PG_HI: begin
          skip_cnt <= skip_last;
          if (range_ok) state <= ST_SKIP;
          else begin state <= ST_DONE; err_q <= 1'b1; end
        end
        ST_SKIP: begin
          if (skip_cnt != '0) begin
            skip_cnt <= skip_cnt - SKIP_W'(1);
          end else begin
            seg_left <= seg_left - SEG_W'(1);
            if (trunc) begin
              state <= ST_DONE;
              err_q <= 1'b1;
            end else if (seg_left == SEG_W'(1)) begin
              state    <= ST_TABLE;
              skip_cnt <= SKIP_W'(TABLE_BYTES - 1);
            end else begin
              state <= ST_PG_LO;
            end
          end
        end
        ST_TABLE: begin
          if (skip_cnt != '0) begin
            skip_cnt <= skip_cnt - SKIP_W'(1);
          end else begin
            state <= ST_DONE;
            if (body_small) err_q  <= 1'b1;
            else            body_q <= body_calc;
          end
        end
        default: state <= state;
      endcase
    end
  end

endmodule

// File: rtl/rom_img_validator_chk.sv
module rom_img_validator_chk #(
  parameter int LEN_W    = 24,
  parameter int MIN_BODY = 52
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             s_valid,
  input logic             s_ready,
  input logic             done,
  input logic             error,
  input logic [LEN_W-1:0] body_len,
  input logic [LEN_W-1:0] flen_q
);

  // R10
  halt_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !s_ready);

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(error) && $stable(body_len)));

  // R10
  err_zero_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (done && body_len == '0));

  // R1
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !error && body_len == '0));

  // R8
  body_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> (body_len <= flen_q));

  // R9
  body_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> (body_len > LEN_W'(MIN_BODY)));

  // R11
  done_on_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(s_valid && s_ready));

endmodule

bind rom_img_validator rom_img_validator_chk #(
  .LEN_W    (LEN_W),
  .MIN_BODY (MIN_BODY)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .done     (done),
  .error    (error),
  .body_len (body_len),
  .flen_q   (flen_q)
);

// File: tb/rom_img_validator_test.sv
module rom_img_validator_test;

  localparam int LW   = 16;
  localparam int PG   = 4;
  localparam int TB   = 6;
  localparam int MINB = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] file_len = '0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [7:0]    s_data = '0;
  logic          done, error;
  logic [LW-1:0] body_len;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] img [0:4095];
  logic [7:0] magic, cnt, chk;
  int lo_a [32];
  int hi_a [32];
  int full_len;

  always #2 clk = ~clk;

  rom_img_validator #(
    .LEN_W(LW), .PAGE_BYTES(PG), .TABLE_BYTES(TB), .MIN_BODY(MINB)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .file_len(file_len),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .done(done), .error(error), .body_len(body_len)
  );

  task automatic chk_val(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      misses++;
      $display("FAIL watchdog: got %0d cycles expected below 190000", cycles);
      finish_run();
    end
  end

  // lay out header, segments, table region and some tag bytes
  task automatic build();
    int p, n, ns;
    for (int i = 0; i < 4096; i++) img[i] = 8'((i * 13 + 5) & 255);
    img[0] = magic; img[1] = cnt; img[2] = chk;
    p = 3;
    ns = (cnt > 32) ? 32 : int'(cnt);
    for (int k = 0; k < ns; k++) begin
      img[p] = 8'(lo_a[k]); img[p+1] = 8'(hi_a[k]);
      p += 2;
      n = (hi_a[k] >= lo_a[k]) ? (hi_a[k] + 1 - lo_a[k]) * PG + 2 : 0;
      p += n;
    end
    full_len = p + TB;
  endtask

  // expected result from the requirements
  task automatic model(input int flen, output bit e, output int body, output int used);
    int pos;
    e = 1'b1; body = 0;
    if (!(magic == 8'hA8 || magic == 8'h61 || magic == 8'h41)) begin used = 1; return; end
    if (cnt < 1 || cnt > 32) begin used = 2; return; end
    if (chk != (cnt ^ 8'hFF)) begin used = 3; return; end
    pos = 3;
    for (int k = 0; k < int'(cnt); k++) begin
      pos += 2;
      if (lo_a[k] > hi_a[k]) begin used = pos; return; end
      pos += (hi_a[k] + 1 - lo_a[k]) * PG + 2;
      if (pos > flen - TB) begin used = pos; return; end
    end
    pos += TB;
    used = pos;
    body = (pos < flen) ? pos : flen;
    if (body <= MINB) begin body = 0; return; end
    e = 1'b0;
  endtask

  task automatic pulse_start(input int flen);
    @(negedge clk);
    file_len = LW'(flen);
    start = 1'b1;
    s_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed(input int limit, output int acc, output bit hung);
    int idx = 0;
    bit fire = 1'b0;
    int cyc = 0;
    hung = 1'b0;
    forever begin
      if (fire) idx++;
      if (done || idx >= limit) break;
      if (cyc > 6000) begin hung = 1'b1; break; end
      if (!(s_valid && !s_ready)) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        s_valid = lfsr[0] | lfsr[1];
      end
      s_data = img[idx & 4095];
      fire = s_valid && s_ready;
      cyc++;
      @(negedge clk);
    end
    s_valid = 1'b0;
    acc = idx;
  endtask

  task automatic apply(input string req, input int flen, input int pre);
    bit e;
    int body, used, acc, extra;
    bit hung;
    build();
    model(flen, e, body, used);
    if (pre > 0) begin
      pulse_start(flen);
      feed(pre, acc, hung);
    end
    pulse_start(flen);
    chk_val("R1", "ready after start", int'(s_ready), 1);
    feed(100000, acc, hung);
    if (hung) chk_val(req, "run timed out", 1, 0);
    chk_val(req, "done", int'(done), 1);
    chk_val(req, "error", int'(error), int'(e));
    chk_val(req, "body_len", int'(body_len), body);
    chk_val("R11", "bytes taken", acc, used);
    extra = 0;
    s_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (s_ready) extra++;
      @(negedge clk);
    end
    s_valid = 1'b0;
    chk_val("R10", "bytes after done", extra, 0);
    chk_val("R10", "done held", int'(done), 1);
  endtask

  task automatic good_hdr(input int n);
    magic = 8'hA8; cnt = 8'(n); chk = 8'(n) ^ 8'hFF;
    for (int k = 0; k < 32; k++) begin lo_a[k] = k % 3; hi_a[k] = (k % 3) + 1; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_val("R1", "done at reset", int'(done), 0);
    chk_val("R1", "error at reset", int'(error), 0);
    chk_val("R1", "ready at reset", int'(s_ready), 0);
    chk_val("R1", "body at reset", int'(body_len), 0);
    rst_n = 1'b1;

    // R2: every signature value
    for (int m = 0; m < 256; m++) begin
      good_hdr(1);
      magic = 8'(m);
      build();
      apply("R2", full_len + 3, 0);
    end

    // R3: counts across and beyond the legal range
    for (int c = 0; c < 40; c++) begin
      good_hdr(c);
      magic = 8'h61;
      build();
      apply("R3", full_len + 2, 0);
    end

    // R4: complement byte off by a single bit
    for (int b = 0; b < 8; b++) begin
      good_hdr(5);
      magic = 8'h41;
      chk = chk ^ 8'(1 << b);
      build();
      apply("R4", full_len, 0);
    end

    // R5 R6: page ranges in a two-segment image
    for (int lo = 0; lo < 8; lo++) begin
      for (int hi = 0; hi < 8; hi++) begin
        good_hdr(2);
        lo_a[1] = lo; hi_a[1] = hi;
        build();
        apply("R6", full_len + 1, 0);
      end
    end
    good_hdr(1);
    lo_a[0] = 0; hi_a[0] = 255;
    build();
    apply("R6", full_len + 5, 0);
    good_hdr(1);
    lo_a[0] = 255; hi_a[0] = 254;
    build();
    apply("R5", full_len, 0);

    // R7 R8: file length around the truncation boundary
    for (int d = -30; d <= 6; d++) begin
      good_hdr(3);
      build();
      apply("R7", full_len + d, 0);
    end
    good_hdr(32);
    build();
    apply("R8", full_len, 0);

    // R9: bodies near the minimum
    for (int h = 0; h < 3; h++) begin
      good_hdr(1);
      lo_a[0] = 0; hi_a[0] = h;
      build();
      apply("R9", full_len, 0);
    end

    // R1: restart in the middle of a walk
    for (int pre = 1; pre < 12; pre++) begin
      good_hdr(2);
      build();
      apply("R1", full_len + 4, pre);
    end

    finish_run();
  end

endmodule